// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns one vector memory operation into a stream of per-element memory requests. A single start pulse captures a base address, an addressing mode, a signed stride, a packed vector of per-element offsets and an element count. From the next cycle on, the block offers one request per cycle. Each request carries the element number, the full element-granular address, the bank that address falls in, and the address inside that bank.

The same sequence serves both loads and stores. There are three modes: unit step, constant signed stride, and indexed access (gather or scatter) from a per-element offset vector. Memory is spread over 16 interleaved banks, so consecutive addresses fall in different banks. Requests leave under a valid/ready handshake. A stalled request is held unchanged. A one-cycle completion pulse follows the last accepted element.

Top module: `vec_addr_gen`

## Requirements
- R1: While reset is held and after it is released with no start, req_valid, done and busy are all 0.
- R2: Mode code 0 (unit step) gives element i the address base + i, modulo 2^32.
- R3: Mode code 1 (strided) gives element i the address base + i*stride. The stride is a signed two's-complement 32-bit value, and the sum wraps modulo 2^32.
- R4: Mode code 2 (indexed) gives element i the address base + index[i]. index[i] sits at bits [32i+31:32i] of index_vec and is captured at the start pulse.
- R5: Mode code 3 behaves exactly as unit step.
- R6: req_bank is bits [3:0] of req_addr, and req_line is bits [31:4] of req_addr.
- R7: The first request is valid in the cycle after start. Elements are numbered 0 to vlen-1 in order. While ready is held high, one element is accepted per cycle.
- R8: While req_valid is high and req_ready is low, the request (element, address, bank, line) stays unchanged and no element is skipped.
- R9: done is high for exactly the one cycle after the final element is accepted, and req_valid is low in that cycle.
- R10: A start with vlen = 0 gives done in the next cycle and no request.
- R11: busy is high while requests remain. A start pulse while busy is ignored: the running sequence and its captured operands do not change. A start in the done cycle is accepted.
- R12: A vlen greater than 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new operation (taken only when not busy) |
| mode | input | 2 | 0/3 unit step, 1 strided, 2 indexed |
| base | input | 32 | Base element address |
| stride | input | 32 | Signed element stride |
| vlen | input | 5 | Element count |
| index_vec | input | 512 | Sixteen packed 32-bit offsets |
| busy | output | 1 | Requests still pending |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Consumer accepts the request |
| req_elem | output | 4 | Element number |
| req_addr | output | 32 | Element address |
| req_bank | output | 4 | Target bank |
| req_line | output | 28 | Address inside the bank |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in one cycle: the completion pulse of one operation and the start of the next. They also overlap when a start pulse arrives while an element is being accepted mid-sequence. The bench drives start in the very cycle done is observed and expects the new operation's element 0 in the next cycle. In a separate run it pulses start with different operands during an active run and expects every following address to keep following the original operands. Stalls are forced in a fixed pattern in the middle of strided and indexed runs, and each held request is compared with the same expected element again.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    AG_UNIT     = 2'd0,
    AG_STRIDE   = 2'd1,
    AG_INDEX    = 2'd2,
    AG_UNIT_ALT = 2'd3
  } ag_mode_e;
endpackage

// File: rtl/vag_seq.sv
module vag_seq #(
  parameter int MAX_VL = 16,
  parameter int VL_W   = 5,
  parameter int EW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vlen,
  input  logic            ready,
  output logic            active,
  output logic [EW-1:0]   elem,
  output logic            done,
  output logic            launch,
  output logic            accept,
  output logic            last
);
  logic [VL_W-1:0] vl_eff;
  logic [VL_W-1:0] vl_m1;
  logic [EW-1:0]   last_r;

  assign vl_eff = (vlen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vlen;
  assign vl_m1  = vl_eff - VL_W'(1);
  assign launch = start & ~active;
  assign accept = active & ready;
  assign last   = accept && (elem == last_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      elem   <= '0;
      done   <= 1'b0;
      last_r <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        elem   <= '0;
        last_r <= vl_m1[EW-1:0];
        active <= (vl_eff != '0);
        done   <= (vl_eff == '0);
      end else if (accept) begin
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          elem <= elem + EW'(1);
        end
      end
    end
  end

  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last |=> active && (elem == $past(elem) + EW'(1))); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active && !ready |=> active && $stable(elem)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !launch |=> !done); // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    launch && (vlen == '0) |=> done && !active); // R10
endmodule

// File: rtl/vag_addr.sv
module vag_addr
  import vag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MAX_VL = 16,
  parameter int EW     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         mode,
  input  logic [AW-1:0]      base,
  input  logic [AW-1:0]      stride,
  input  logic [MAX_VL*AW-1:0] idx_flat,
  input  logic [EW-1:0]      elem,
  output logic [AW-1:0]      addr,
  output ag_mode_e           mode_q,
  output logic [AW-1:0]      base_q
);
  logic [AW-1:0] stride_q;
  logic [AW-1:0] idx_q [MAX_VL];

  function automatic logic [AW-1:0] elem_offset(
    input ag_mode_e m, input logic [AW-1:0] s,
    input logic [AW-1:0] ix, input logic [EW-1:0] i);
    logic [AW-1:0] iw;
    iw = {{(AW-EW){1'b0}}, i};
    case (m)
      AG_STRIDE: elem_offset = s * iw;
      AG_INDEX:  elem_offset = ix;
      default:   elem_offset = iw;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= AG_UNIT;
      base_q   <= '0;
      stride_q <= '0;
    end else if (load) begin
      mode_q   <= ag_mode_e'(mode);
      base_q   <= base;
      stride_q <= stride;
    end
  end

  for (genvar g = 0; g < MAX_VL; g++) begin : g_idx
    always_ff @(posedge clk) begin
      if (!rst_n) idx_q[g] <= '0;
      else if (load) idx_q[g] <= idx_flat[g*AW +: AW];
    end
  end

  assign addr = base_q + elem_offset(mode_q, stride_q, idx_q[elem], elem);
endmodule

// File: rtl/vag_bank.sv
module vag_bank #(
  parameter int AW     = 32,
  parameter int BANK_W = 4
) (
  input  logic [AW-1:0]        addr,
  output logic [BANK_W-1:0]    bank,
  output logic [AW-BANK_W-1:0] line
);
  assign bank = addr[BANK_W-1:0];
  assign line = addr[AW-1:BANK_W];
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MAX_VL = 16,
  parameter int NBANK  = 16,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int EW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        stride,
  input  logic [VL_W-1:0]      vlen,
  input  logic [MAX_VL*AW-1:0] index_vec,
  output logic                 busy,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [EW-1:0]        req_elem,
  output logic [AW-1:0]        req_addr,
  output logic [BANK_W-1:0]    req_bank,
  output logic [AW-BANK_W-1:0] req_line,
  output logic                 done
);
  logic     active, launch, accept, last;
  ag_mode_e cur_mode;
  logic [AW-1:0] cur_base;

  vag_seq #(.MAX_VL(MAX_VL), .VL_W(VL_W), .EW(EW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .ready(req_ready),
    .active(active), .elem(req_elem), .done(done), .launch(launch),
    .accept(accept), .last(last)
  );

  vag_addr #(.AW(AW), .MAX_VL(MAX_VL), .EW(EW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(launch), .mode(mode), .base(base),
    .stride(stride), .idx_flat(index_vec), .elem(req_elem), .addr(req_addr),
    .mode_q(cur_mode), .base_q(cur_base)
  );

  vag_bank #(.AW(AW), .BANK_W(BANK_W)) u_bank (
    .addr(req_addr), .bank(req_bank), .line(req_line)
  );

  assign busy      = active;
  assign req_valid = active;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_elem) && $stable(req_bank)); // R8
  AST_FIRST_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
    launch && (vlen != '0) |=> req_valid && (req_elem == '0)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid); // R9
  AST_BANK_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last && ((cur_mode == AG_UNIT) || (cur_mode == AG_UNIT_ALT))
    |=> req_bank == BANK_W'($past(req_bank) + BANK_W'(1))); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(cur_base) && $stable(cur_mode)); // R11
endmodule

// File: tb/vec_addr_gen_test.sv
module vec_addr_gen_test;
  localparam int AW = 32, MAX_VL = 16, VL_W = 5, EW = 4, BW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, req_ready, busy, req_valid, done;
  logic [1:0] mode;
  logic [AW-1:0] base, stride, req_addr;
  logic [VL_W-1:0] vlen;
  logic [MAX_VL*AW-1:0] index_vec;
  logic [EW-1:0] req_elem;
  logic [BW-1:0] req_bank;
  logic [AW-BW-1:0] req_line;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] idx [MAX_VL];

  vec_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .stride(stride), .vlen(vlen), .index_vec(index_vec), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_elem(req_elem),
    .req_addr(req_addr), .req_bank(req_bank), .req_line(req_line), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int m, input logic [AW-1:0] b,
                                             input logic [AW-1:0] s, input int i);
    logic [AW-1:0] a;
    a = b;
    if (m == 1) begin
      for (int k = 0; k < i; k++) a = a + s;
    end else if (m == 2) begin
      a = b + idx[i];
    end else begin
      a = b + AW'(i);
    end
    return a;
  endfunction

  // Called at a negedge; returns at the negedge where done is expected.
  task automatic run(input int m, input logic [AW-1:0] b, input logic [AW-1:0] s,
                     input int vl, input bit stall, input bit poke);
    int eff, i, c;
    string tag;
    logic [AW-1:0] ea;
    tag = (m == 1) ? "R3" : (m == 2) ? "R4" : (m == 3) ? "R5" : "R2";
    mode = 2'(m); base = b; stride = s; vlen = VL_W'(vl); start = 1'b1; req_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    eff = (vl > MAX_VL) ? MAX_VL : vl;
    if (eff == 0) begin
      chk("R10 done", 64'(done), 64'd1);
      chk("R10 valid", 64'(req_valid), 64'd0);
      return;
    end
    i = 0; c = 0;
    while (i < eff) begin
      ea = exp_addr(m, b, s, i);
      chk("R7 valid", 64'(req_valid), 64'd1);
      chk("R11 busy", 64'(busy), 64'd1);
      chk(vl > MAX_VL ? "R12 elem" : (c != i ? "R8 elem" : "R7 elem"), 64'(req_elem), 64'(i));
      chk({tag, " addr"}, 64'(req_addr), 64'(ea));
      chk("R6 bank", 64'(req_bank), 64'(ea[3:0]));
      chk("R6 line", 64'(req_line), 64'(ea[AW-1:4]));
      req_ready = stall ? ((c % 3) != 1) : 1'b1;
      if (poke && i == 1) begin
        start = 1'b1; base = ~b; stride = s + 5; mode = 2'd2; vlen = 5'd2;
      end
      @(negedge clk);
      start = 1'b0; base = b; stride = s; mode = 2'(m);
      if (req_ready) i++;
      c++;
    end
    req_ready = 1'b1;
    chk("R9 done", 64'(done), 64'd1);
    chk("R9 valid", 64'(req_valid), 64'd0);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R9 done low", 64'(done), 64'd0);
    chk("R9 valid low", 64'(req_valid), 64'd0);
    chk("R11 busy low", 64'(busy), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] strides [8];
    rst_n = 1'b0; start = 1'b0; req_ready = 1'b1; mode = 2'd0;
    base = '0; stride = '0; vlen = '0; index_vec = '0;
    for (int k = 0; k < MAX_VL; k++) begin
      idx[k] = AW'(k * 37) - 32'd300 + (AW'(k) << 20);
      index_vec[k*AW +: AW] = idx[k];
    end
    repeat (3) @(negedge clk);
    chk("R1 valid", 64'(req_valid), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 64'(req_valid), 64'd0);
    chk("R1 busy after reset", 64'(busy), 64'd0);

    // Unit step, every length, back to back (start in each done cycle)
    for (int vl = 0; vl <= MAX_VL; vl++) run(0, 32'h0000_1000 + AW'(vl * 3), 0, vl, 1'b0, 1'b0);
    idle_check();

    // Strided sweep with and without stalls
    strides[0] = 32'd1; strides[1] = 32'hFFFF_FFFF; strides[2] = 32'd3; strides[3] = 32'd16;
    strides[4] = 32'd17; strides[5] = 32'd0; strides[6] = 32'h7FFF_FFFF; strides[7] = 32'h8000_0000;
    for (int s = 0; s < 8; s++) begin
      run(1, 32'h0000_4000, strides[s], 1, 1'b0, 1'b0);
      run(1, 32'hFFFF_FFF0, strides[s], 5, 1'b1, 1'b0);
      run(1, 32'h1234_5670, strides[s], 16, s[0], 1'b0);
    end
    idle_check();

    // Indexed gather/scatter
    run(2, 32'h0000_8000, 0, 16, 1'b1, 1'b0);
    run(2, 32'hFFFF_FF00, 0, 7, 1'b0, 1'b0);
    idle_check();

    // Alternate unit code, wrap at top of address space
    run(3, 32'hFFFF_FFF8, 0, 16, 1'b1, 1'b0);
    run(0, 32'hFFFF_FFFA, 0, 12, 1'b0, 1'b0);
    idle_check();

    // Start while busy is ignored
    run(1, 32'h0000_2000, 32'd7, 6, 1'b0, 1'b1);
    run(2, 32'h0000_3000, 0, 9, 1'b1, 1'b1);
    idle_check();

    // Over-long length saturates
    run(0, 32'h0000_0100, 0, 20, 1'b0, 1'b0);
    run(1, 32'h0000_0200, 32'd2, 31, 1'b1, 1'b0);
    idle_check();

    // Zero length followed by normal run
    run(0, 32'h0, 0, 0, 1'b0, 1'b0);
    idle_check();
    run(0, 32'h0, 0, 0, 1'b0, 1'b0);
    run(1, 32'h0000_0040, 32'hFFFF_FFFC, 4, 1'b0, 1'b0);
    idle_check();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule